// File: doc/BRIEF.md
# Serial Command Sequencer for Coefficient Load and Position Update

This block sits behind a UART byte assembler and reads the 16-bit words it produces. A small state machine recognises two opcodes. Opcode `0x0000` starts a bulk load: every following word is a filter coefficient and goes out on an external memory write port at consecutive addresses, until a fixed number of coefficients (250,000 by default) have been written. Opcode `0x0001` starts a position update: the next word is stored as azimuth, the word after that as elevation, and then a single-cycle pulse tells the coefficient control logic that a new position is ready.

The states are `ST_IDLE` (waits for an opcode), `ST_LOAD` (bulk load), `ST_AZIM` (waits for the azimuth word), `ST_ELEV` (waits for the elevation word) and `ST_FIRE` (drives the update pulse). The transitions are: IDLE to LOAD on word `0x0000`, IDLE to AZIM on word `0x0001`, LOAD to IDLE on the final coefficient write, AZIM to ELEV on any word, ELEV to FIRE on any word, and FIRE to IDLE after one cycle. In load mode, each word goes into a one-entry holding register. The memory write strobe rises in the same cycle that the holding register is full and the port reports ready.

Top module: `coef_cmd_sequencer`

## Requirements
- R1: In `ST_IDLE`, every word other than `0x0000` and `0x0001` is ignored: no memory write, no register change, no pulse, and the next word is still decoded as an opcode.
- R2: Word `0x0000` in idle starts a bulk load that issues exactly `LOAD_COUNT` memory writes and then returns to idle, so the next word is decoded as an opcode again.
- R3: Word `0x0001` in idle makes the next valid word the new `azim` value.
- R4: The valid word after the azimuth word becomes the new `elev` value.
- R5: `upd_pulse` is high for exactly one cycle, in the cycle after the elevation word is taken. At that point `azim` and `elev` already hold the new values. A word presented during that cycle is ignored.
- R6: The write address is 0 for the first coefficient of every bulk load and goes up by one with each write.
- R7: `mem_we` is high only when a coefficient word is held and `mem_rdy` is high. While `mem_rdy` is low, the held word and its address stay unchanged.
- R8: A word that arrives in load mode while the held word is waiting and is not being written in that cycle is discarded.
- R9: Synchronous `rst` returns the block to idle, clears the address counter, drops any held word and clears `azim` and `elev` to 0.
- R10: During a bulk load, the words `0x0000` and `0x0001` are written as coefficient data and are not decoded as opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | One-cycle strobe: a new word is present |
| word_dat | input | 16 | Received word |
| mem_rdy | input | 1 | Memory port can take a write this cycle |
| mem_we | output | 1 | Coefficient write strobe |
| mem_addr | output | ADDR_W (18) | Coefficient write address |
| mem_dat | output | 16 | Coefficient write data |
| azim | output | 16 | Captured azimuth word |
| elev | output | 16 | Captured elevation word |
| upd_pulse | output | 1 | One-cycle position-update trigger |

## Verification
Two situations are hard to reach from the ports. The first is a word arriving while an earlier coefficient is still blocked. The second is the last coefficient write, which has to return the machine to idle. The bench builds the block with a small `LOAD_COUNT` so that the end of a load arrives within a few cycles. It holds `mem_rdy` low after one coefficient and sends a second word, which must be discarded. It then releases the port and finishes the load, and checks the order of the write log and the return to opcode decoding.

// File: rtl/coef_cmd_pkg.sv
package coef_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_AZIM,
        ST_ELEV,
        ST_FIRE
    } cmd_state_e;

    localparam int PRM_AZIM   = 0;
    localparam int PRM_ELEV   = 1;
    localparam int NUM_PARAMS = 2;

endpackage

// File: rtl/load_addr_counter.sv
module load_addr_counter #(
    parameter int LIMIT = 250000,
    parameter int AW    = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] cnt,
    output logic          at_last
);

    localparam logic [AW-1:0] LAST_IDX = AW'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == LAST_IDX);

    // R6: each write moves the address on by exactly one
    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (cnt == AW'($past(cnt) + 1'b1)));

    // R9: reset clears the counter
    p_cnt_reset_r9: assert property (@(posedge clk)
        rst |=> (cnt == '0));

endmodule

// File: rtl/coef_write_stage.sv
module coef_write_stage #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          in_vld,
    input  logic [DW-1:0] in_dat,
    input  logic          mem_rdy,
    input  logic          last_slot,
    output logic          we,
    output logic [DW-1:0] out_dat
);

    logic          pend_v;
    logic [DW-1:0] pend_dat;
    logic          take;

    assign we   = active && pend_v && mem_rdy;
    assign take = active && in_vld && (!pend_v || we) && !(we && last_slot);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pend_v <= 1'b0;
        end else if (take) begin
            pend_v <= 1'b1;
        end else if (we) begin
            pend_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            pend_dat <= in_dat;
        end
    end

    assign out_dat = pend_dat;

    // R7 / R8: a blocked word stays put, later arrivals do not overwrite it
    p_hold_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        (active && pend_v && !mem_rdy) |=> (!active || (pend_v && $stable(pend_dat))));

    // R7: a write strobe always has a held word behind it
    p_we_has_word_r7: assert property (@(posedge clk) disable iff (rst)
        we |-> (pend_v && mem_rdy));

endmodule

// File: rtl/param_capture_regs.sv
module param_capture_regs #(
    parameter int DW = 16,
    parameter int N  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         wr_sel,
    input  logic [DW-1:0]        wr_dat,
    output logic [N-1:0][DW-1:0] vals
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                vals[g] <= '0;
            end else if (wr_sel[g]) begin
                vals[g] <= wr_dat;
            end
        end

        // R3 / R4: a slot changes only when selected
        p_slot_keep_r3: assert property (@(posedge clk) disable iff (rst)
            !wr_sel[g] |=> $stable(vals[g]));
    end

    p_sel_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

endmodule

// File: rtl/coef_cmd_sequencer.sv
module coef_cmd_sequencer
    import coef_cmd_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int LOAD_COUNT = 250000,
    parameter int ADDR_W     = $clog2(LOAD_COUNT),
    parameter logic [WORD_W-1:0] OP_LOAD = 'h0000,
    parameter logic [WORD_W-1:0] OP_POS  = 'h0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_dat,
    input  logic              mem_rdy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_dat,
    output logic [WORD_W-1:0] azim,
    output logic [WORD_W-1:0] elev,
    output logic              upd_pulse
);

    cmd_state_e state_q, state_d;

    logic                           load_active;
    logic                           cnt_clr;
    logic                           at_last;
    logic [NUM_PARAMS-1:0]          cap_sel;
    logic [NUM_PARAMS-1:0][WORD_W-1:0] cap_vals;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (word_vld && word_dat == OP_LOAD) begin
                    state_d = ST_LOAD;
                end else if (word_vld && word_dat == OP_POS) begin
                    state_d = ST_AZIM;
                end
            end
            ST_LOAD: if (mem_we && at_last) state_d = ST_IDLE;
            ST_AZIM: if (word_vld) state_d = ST_ELEV;
            ST_ELEV: if (word_vld) state_d = ST_FIRE;
            ST_FIRE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        load_active = 1'b0;
        cnt_clr     = 1'b0;
        cap_sel     = '0;
        upd_pulse   = 1'b0;
        unique case (state_q)
            ST_IDLE: cnt_clr = 1'b1;
            ST_LOAD: load_active = 1'b1;
            ST_AZIM: cap_sel[PRM_AZIM] = word_vld;
            ST_ELEV: cap_sel[PRM_ELEV] = word_vld;
            ST_FIRE: upd_pulse = 1'b1;
            default: cnt_clr = 1'b1;
        endcase
    end

    load_addr_counter #(
        .LIMIT (LOAD_COUNT),
        .AW    (ADDR_W)
    ) addr_cnt_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .inc     (mem_we),
        .cnt     (mem_addr),
        .at_last (at_last)
    );

    coef_write_stage #(
        .DW (WORD_W)
    ) wr_stage_i (
        .clk       (clk),
        .rst       (rst),
        .active    (load_active),
        .in_vld    (word_vld),
        .in_dat    (word_dat),
        .mem_rdy   (mem_rdy),
        .last_slot (at_last),
        .we        (mem_we),
        .out_dat   (mem_dat)
    );

    param_capture_regs #(
        .DW (WORD_W),
        .N  (NUM_PARAMS)
    ) cap_regs_i (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (cap_sel),
        .wr_dat (word_dat),
        .vals   (cap_vals)
    );

    assign azim = cap_vals[PRM_AZIM];
    assign elev = cap_vals[PRM_ELEV];

    // R1: words other than the two opcodes leave idle unchanged
    p_idle_ignore_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && word_vld && word_dat != OP_LOAD && word_dat != OP_POS)
        |=> (state_q == ST_IDLE && !mem_we));

    // R2: final coefficient write ends the load
    p_load_exit_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD && mem_we && at_last) |=> (state_q == ST_IDLE));

    // R5: pulse is a single cycle and follows the elevation word
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> !upd_pulse);

    p_pulse_after_elev_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(upd_pulse) |-> ($past(state_q) == ST_ELEV && $past(word_vld)));

    // R7: no write outside load mode
    p_we_in_load_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (state_q == ST_LOAD && mem_rdy));

    // R9: reset lands in idle
    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE && !upd_pulse));

endmodule

// File: tb/coef_cmd_sequencer_tb_top.sv
module coef_cmd_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LCOUNT     = 6;
    localparam int AW         = $clog2(LCOUNT);

    logic          clk = 1'b0;
    logic          rst;
    logic          word_vld;
    logic [15:0]   word_dat;
    logic          mem_rdy;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_dat;
    logic [15:0]   azim;
    logic [15:0]   elev;
    logic          upd_pulse;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int wr_cnt = 0;
    int log_addr [32];
    int log_dat  [32];
    int pulse_cnt = 0;
    int pulse_azim, pulse_elev;
    int pulse_runs = 0;
    bit prev_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coef_cmd_sequencer #(
        .WORD_W     (16),
        .LOAD_COUNT (LCOUNT),
        .ADDR_W     (AW)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .word_vld  (word_vld),
        .word_dat  (word_dat),
        .mem_rdy   (mem_rdy),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_dat   (mem_dat),
        .azim      (azim),
        .elev      (elev),
        .upd_pulse (upd_pulse)
    );

    // write and pulse monitors (values before the edge)
    always @(posedge clk) begin
        if (!rst && mem_we) begin
            if (wr_cnt < 32) begin
                log_addr[wr_cnt] = int'(mem_addr);
                log_dat[wr_cnt]  = int'(mem_dat);
            end
            wr_cnt++;
        end
        if (!rst && upd_pulse) begin
            pulse_cnt++;
            pulse_azim = int'(azim);
            pulse_elev = int'(elev);
            if (prev_pulse) pulse_runs++;
        end
        prev_pulse = upd_pulse;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        word_vld = 1'b1;
        word_dat = w;
        @(negedge clk);
        word_vld = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        wr_cnt = 0;
        pulse_cnt = 0;
    endtask

    task automatic test_reset_state();
        #1;
        chk(mem_we == 1'b0, "R9 we", int'(mem_we), 0);
        chk(azim == 16'h0 && elev == 16'h0, "R9 regs", int'({azim, elev}), 0);
        chk(upd_pulse == 1'b0, "R9 pulse", int'(upd_pulse), 0);
        chk(mem_addr == '0, "R9 addr", int'(mem_addr), 0);
    endtask

    task automatic test_position();
        pulse_cnt = 0; pulse_runs = 0;
        send_word(16'h0001);
        send_word(16'hABCD);
        #1;
        chk(azim == 16'hABCD, "R3 azim", int'(azim), 'hABCD);
        send_word(16'h0123);
        idle_cycles(3);
        chk(elev == 16'h0123, "R4 elev", int'(elev), 'h0123);
        chk(pulse_cnt == 1, "R5 pulse count", pulse_cnt, 1);
        chk(pulse_runs == 0, "R5 pulse width", pulse_runs, 0);
        chk(pulse_azim == 'hABCD && pulse_elev == 'h0123, "R5 values at pulse",
            pulse_elev, 'h0123);
    endtask

    task automatic test_pulse_cycle_word();
        // word presented in the pulse cycle is ignored (R5)
        pulse_cnt = 0;
        send_word(16'h0001);
        send_word(16'h0A0A);
        @(negedge clk);
        word_vld = 1'b1; word_dat = 16'h0B0B;
        @(negedge clk);
        word_vld = 1'b1; word_dat = 16'h0001;   // lands in pulse cycle
        @(negedge clk);
        word_vld = 1'b0;
        send_word(16'h0C0C);                    // would be azim if R5 broken
        idle_cycles(2);
        chk(azim == 16'h0A0A, "R5 word in pulse cycle ignored", int'(azim), 'h0A0A);
        chk(pulse_cnt == 1, "R5 single pulse", pulse_cnt, 1);
    endtask

    task automatic test_junk_idle();
        int w0 = wr_cnt;
        pulse_cnt = 0;
        send_word(16'h0002);
        send_word(16'hFFFF);
        send_word(16'h8000);
        idle_cycles(2);
        chk(wr_cnt == w0, "R1 no write", wr_cnt, w0);
        chk(pulse_cnt == 0, "R1 no pulse", pulse_cnt, 0);
        chk(azim == 16'h0A0A, "R1 azim kept", int'(azim), 'h0A0A);
        send_word(16'h0001);
        send_word(16'h1111);
        send_word(16'h2222);
        idle_cycles(2);
        chk(azim == 16'h1111, "R1 opcode after junk", int'(azim), 'h1111);
    endtask

    task automatic test_load_plain();
        int exp_d [LCOUNT] = '{'h5000, 'h0001, 'h0000, 'h5003, 'hFFFF, 'h5005};
        mem_rdy = 1'b1;
        wr_cnt = 0;
        send_word(16'h0000);
        for (int i = 0; i < LCOUNT; i++) send_word(16'(exp_d[i]));
        idle_cycles(3);
        chk(wr_cnt == LCOUNT, "R2 write count", wr_cnt, LCOUNT);
        for (int i = 0; i < LCOUNT; i++) begin
            chk(log_addr[i] == i, "R6 address", log_addr[i], i);
            chk(log_dat[i] == exp_d[i], "R10 data", log_dat[i], exp_d[i]);
        end
        send_word(16'h0001);
        send_word(16'h3333);
        send_word(16'h4444);
        idle_cycles(2);
        chk(azim == 16'h3333 && elev == 16'h4444, "R2 back to idle", int'(azim), 'h3333);
        chk(wr_cnt == LCOUNT, "R2 no extra write", wr_cnt, LCOUNT);
    endtask

    task automatic test_load_backpressure();
        mem_rdy = 1'b0;
        wr_cnt = 0;
        send_word(16'h0000);
        send_word(16'h7000);
        idle_cycles(3);
        #1;
        chk(mem_we == 1'b0, "R7 no write when busy", int'(mem_we), 0);
        chk(wr_cnt == 0, "R7 nothing written", wr_cnt, 0);
        send_word(16'h7001);                     // dropped (R8)
        @(negedge clk);
        mem_rdy = 1'b1;
        #1;
        chk(mem_we == 1'b1 && mem_dat == 16'h7000, "R7 held word written", int'(mem_dat), 'h7000);
        for (int i = 2; i < LCOUNT + 1; i++) send_word(16'(16'h7000 + i));
        idle_cycles(3);
        chk(wr_cnt == LCOUNT, "R8 write count", wr_cnt, LCOUNT);
        chk(log_dat[0] == 'h7000, "R7 first data", log_dat[0], 'h7000);
        chk(log_dat[1] == 'h7002, "R8 overrun word dropped", log_dat[1], 'h7002);
        chk(log_addr[0] == 0 && log_addr[LCOUNT-1] == LCOUNT-1, "R6 restart at zero",
            log_addr[0], 0);
    endtask

    task automatic test_reset_mid_load();
        mem_rdy = 1'b1;
        send_word(16'h0000);
        send_word(16'h6000);
        send_word(16'h6001);
        do_reset();
        #1;
        chk(azim == 16'h0 && mem_addr == '0, "R9 reset mid-load", int'(azim), 0);
        send_word(16'h0001);
        send_word(16'h0042);
        send_word(16'h0043);
        idle_cycles(2);
        chk(wr_cnt == 0 && azim == 16'h0042, "R9 idle after reset", int'(azim), 'h42);
        send_word(16'h0000);
        for (int i = 0; i < LCOUNT; i++) send_word(16'(16'h6100 + i));
        idle_cycles(3);
        chk(wr_cnt == LCOUNT && log_addr[0] == 0, "R9 counter cleared", log_addr[0], 0);
    endtask

    initial begin
        rst = 1'b1; word_vld = 1'b0; word_dat = '0; mem_rdy = 1'b1;
        idle_cycles(3);
        rst = 1'b0;
        test_reset_state();
        test_position();
        test_pulse_cycle_word();
        test_junk_idle();
        test_load_plain();
        test_load_backpressure();
        test_reset_mid_load();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule